// File: doc/BRIEF.md
# Fractional Phase-Step PWM Generator

This block drives one pulse-width-modulated output from a single 32-bit control word. A 16-bit phase step is added to a 16-bit accumulator on every enabled clock. The output frequency is therefore `step × f_clk / 65536`, and a PWM cycle ends on the clock where the addition carries out of the accumulator. The output is high while the accumulator's upper byte is below an 8-bit on-time value, which sets the duty cycle.

Software writes new step and on-time values into a holding copy. They do not reach the generator until software sets the load-request bit in the same word. The generator then copies both values into its working registers together, at the next cycle boundary, so no PWM cycle mixes old and new settings. The request bit clears itself on that boundary and can be polled to confirm the load. Clearing the enable bit parks the generator at phase zero with the output low, and keeps the working settings.

Top module: `fpwm_top`

## Requirements
- R1: Control word layout: bit 31 is enable, bit 30 is load request, bits 23:8 are the phase step and bits 7:0 are the on-time. A read returns the last written enable, step and on-time, the live request bit, and zeros in bits 29:24. The read value changes on the clock edge that takes the write.
- R2: While enabled, the accumulator adds the working step on every clock, modulo 65536. A cycle boundary is a clock on which this addition carries out.
- R3: The output is registered. After each clock it equals enable AND (accumulator bits 15:8 < working on-time), both evaluated before that clock. A working on-time of 0 gives a constant low output.
- R4: The working step and on-time change only on a boundary that finds a request pending, and both change on that same edge. A write without the request bit never alters them.
- R5: Writing 1 to bit 30 sets the request. Writing 0 to bit 30 does not clear it. The request clears on the edge that copies the holding values, unless a new write on that edge sets it again.
- R6: While disabled, the accumulator is held at zero and the output is low. When the block is enabled again, the working settings are unchanged and the first output sample comes from phase zero.
- R7: When the working step is zero, every enabled clock counts as a boundary, so a pending request loads on the next enabled clock.
- R8: A step whose upper byte exceeds 128 still runs. With step 0x8100 and on-time 0x40, exactly 64 of any 256 consecutive outputs are high.
- R9: After reset the control word reads as zero, the output is low, and the working step and on-time are zero.
- R10: A request made while disabled stays pending until the block is enabled and reaches a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word value to write |
| rd_data | output | 32 | Control word read-back with the live request bit |
| pwm_out | output | 1 | PWM output |

## Verification
The main function is tried with several step and on-time pairs. A step of 0x0100 with on-times 0, 0x40 and 0xFF checks the compare at zero, mid-range and full scale. Step 0x0200 with an odd on-time checks the coarse-resolution rounding. Step 0x4000 gives a four-clock period, and step 0x8100 covers the out-of-range upper byte.

Each pair is judged by the exact count of high outputs in a 256-clock window. The count differs whenever the compare direction, the field used or the carry handling is wrong. A cycle-level model also compares every output and read-back sample, which separates a load taken immediately from one deferred to the carry. It also catches a request that is lost while disabled and an accumulator that is not cleared on disable.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int CTRL_W      = 32;
  localparam int EN_BIT      = 31;
  localparam int REQ_BIT     = 30;
  localparam int STEP_W_DEF  = 16;
  localparam int DUTY_W_DEF  = 8;
  localparam int RST_SYNC_W  = 2;
endpackage

// File: rtl/fpwm_ctrl_regs.sv
module fpwm_ctrl_regs
  import fpwm_pkg::*;
#(
  parameter int STEP_W = STEP_W_DEF,
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              load_ack,
  output logic              enable,
  output logic              req_pend,
  output logic [STEP_W-1:0] step_hold,
  output logic [DUTY_W-1:0] duty_hold,
  output logic [CTRL_W-1:0] rd_data
);
  localparam int STEP_LSB = DUTY_W;
  localparam int STEP_MSB = STEP_LSB + STEP_W - 1;
  localparam int GAP_W    = REQ_BIT - STEP_MSB - 1;

  logic              en_q, en_n;
  logic              req_q, req_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [DUTY_W-1:0] duty_q, duty_n;
  logic [GAP_W-1:0]  unused_gap;

  assign unused_gap = wr_data[REQ_BIT-1:STEP_MSB+1];

  always_comb begin
    en_n   = en_q;
    step_n = step_q;
    duty_n = duty_q;
    if (wr_en) begin
      en_n   = wr_data[EN_BIT];
      step_n = wr_data[STEP_MSB:STEP_LSB];
      duty_n = wr_data[DUTY_W-1:0];
    end
    req_n = (wr_en & wr_data[REQ_BIT]) | (req_q & ~load_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      req_q  <= 1'b0;
      step_q <= '0;
      duty_q <= '0;
    end else begin
      en_q  <= en_n;
      req_q <= req_n;
      if (wr_en) begin
        step_q <= step_n;
        duty_q <= duty_n;
      end
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[EN_BIT]            = en_q;
    rd_data[REQ_BIT]           = req_q;
    rd_data[STEP_MSB:STEP_LSB] = step_q;
    rd_data[DUTY_W-1:0]        = duty_q;
  end

  assign enable    = en_q;
  assign req_pend  = req_q;
  assign step_hold = step_q;
  assign duty_hold = duty_q;

  // R5: a pending request survives every edge that does not acknowledge it
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !load_ack) |=> req_q);
  // R5: the request only rises through a write carrying bit 30
  assert_req_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !(wr_en && wr_data[REQ_BIT])) |=> !req_q);
  // R1: holding values move only on a write
  assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(step_q) && $stable(duty_q)));
endmodule

// File: rtl/fpwm_phase.sv
module fpwm_phase
  import fpwm_pkg::*;
#(
  parameter int STEP_W = STEP_W_DEF,
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              req_pend,
  input  logic [STEP_W-1:0] step_hold,
  input  logic [DUTY_W-1:0] duty_hold,
  output logic [DUTY_W-1:0] phase_hi,
  output logic [DUTY_W-1:0] duty_act,
  output logic              load_ack
);
  logic [STEP_W-1:0] acc_q, acc_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [DUTY_W-1:0] duty_q, duty_n;
  logic [STEP_W:0]   sum;
  logic              carry;
  logic              step_zero;
  logic              boundary;

  always_comb begin
    sum       = {1'b0, acc_q} + {1'b0, step_q};
    carry     = sum[STEP_W];
    step_zero = (step_q == '0);
    boundary  = enable & (carry | step_zero);
    load_ack  = boundary & req_pend;
    acc_n     = enable ? sum[STEP_W-1:0] : '0;
    step_n    = load_ack ? step_hold : step_q;
    duty_n    = load_ack ? duty_hold : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      step_q <= '0;
      duty_q <= '0;
    end else begin
      acc_q <= acc_n;
      if (load_ack) begin
        step_q <= step_n;
        duty_q <= duty_n;
      end
    end
  end

  assign phase_hi = acc_q[STEP_W-1 -: DUTY_W];
  assign duty_act = duty_q;

  // R6: disabled generator parks at phase zero
  assert_park_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (acc_q == '0));
  // R4: working settings change only on an acknowledged boundary
  assert_act_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ack |=> ($stable(step_q) && $stable(duty_q)));
  // R2: enabled accumulator moves by the working step
  assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (acc_q == $past(acc_q) + $past(step_q)));
  // R7: with a zero step a pending request is taken on the next enabled clock
  assert_zero_step_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && req_pend && step_zero) |-> load_ack);
endmodule

// File: rtl/fpwm_duty.sv
module fpwm_duty
  import fpwm_pkg::*;
#(
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DUTY_W-1:0] phase_hi,
  input  logic [DUTY_W-1:0] duty_act,
  output logic              pwm_out
);
  logic out_q, out_n;

  always_comb begin
    out_n = enable & (phase_hi < duty_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_n;
  end

  assign pwm_out = out_q;

  // R6: disabled means low output on the next sample
  assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !out_q);
  // R3: zero on-time never produces a high sample
  assert_zero_duty_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |=> !out_q);
endmodule

// File: rtl/fpwm_top.sv
module fpwm_top
  import fpwm_pkg::*;
#(
  parameter int STEP_W = STEP_W_DEF,
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              pwm_out
);
  logic [RST_SYNC_W-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic                  enable;
  logic                  req_pend;
  logic                  load_ack;
  logic [STEP_W-1:0]     step_hold;
  logic [DUTY_W-1:0]     duty_hold;
  logic [DUTY_W-1:0]     phase_hi;
  logic [DUTY_W-1:0]     duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_SYNC_W-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_SYNC_W-1];

  fpwm_ctrl_regs #(.STEP_W(STEP_W), .DUTY_W(DUTY_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .load_ack  (load_ack),
    .enable    (enable),
    .req_pend  (req_pend),
    .step_hold (step_hold),
    .duty_hold (duty_hold),
    .rd_data   (rd_data)
  );

  fpwm_phase #(.STEP_W(STEP_W), .DUTY_W(DUTY_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .enable    (enable),
    .req_pend  (req_pend),
    .step_hold (step_hold),
    .duty_hold (duty_hold),
    .phase_hi  (phase_hi),
    .duty_act  (duty_act),
    .load_ack  (load_ack)
  );

  fpwm_duty #(.DUTY_W(DUTY_W)) u_duty (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enable   (enable),
    .phase_hi (phase_hi),
    .duty_act (duty_act),
    .pwm_out  (pwm_out)
  );

  // R9: held in reset the block reads zero and drives low
  assert_reset_state_R9: assert property (@(posedge clk)
    !rst_int_n |=> (rd_data == '0 && !pwm_out));
endmodule

// File: tb/fpwm_top_tb.sv
module fpwm_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam int NVEC       = 6;
  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] REQ = 32'h4000_0000;

  // {step[15:0], on_time[7:0], expected highs in 256 clocks[15:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h0100, 8'h40, 16'd64},
    {16'h0100, 8'h00, 16'd0},
    {16'h0100, 8'hFF, 16'd255},
    {16'h0200, 8'h81, 16'd130},
    {16'h4000, 8'h80, 16'd128},
    {16'h8100, 8'h40, 16'd64}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // cycle model built from the requirements
  logic        m_en, m_req, m_out;
  logic [15:0] m_step_h, m_acc, m_step_a;
  logic [7:0]  m_duty_h, m_duty_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpwm_top u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pwm_out (pwm_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_req = 0; m_out = 0; m_step_h = 0; m_duty_h = 0;
    m_acc = 0; m_step_a = 0; m_duty_a = 0;
  endtask

  task automatic model_clock(input logic we, input logic [31:0] d);
    logic [16:0] s;
    logic        ack;
    s   = {1'b0, m_acc} + {1'b0, m_step_a};
    ack = m_en & (s[16] | (m_step_a == 0)) & m_req;
    m_out = m_en & (m_acc[15:8] < m_duty_a);
    m_acc = m_en ? s[15:0] : 16'h0;
    if (ack) begin m_step_a = m_step_h; m_duty_a = m_duty_h; end
    m_req = (we & d[30]) | (m_req & ~ack);
    if (we) begin m_en = d[31]; m_step_h = d[23:8]; m_duty_h = d[7:0]; end
  endtask

  task automatic step(input logic we, input logic [31:0] d);
    wr_en = we; wr_data = d;
    @(posedge clk);
    model_clock(we, d);
    @(negedge clk);
    wr_en = 0; wr_data = 0;
    check("R3 output vs model", {31'b0, pwm_out}, {31'b0, m_out});
    check("R1 readback vs model", rd_data, {m_en, m_req, 6'b0, m_step_h, m_duty_h});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic wait_loaded(input string tag);
    int k = 0;
    while (rd_data[30] && k < 70000) begin step(0, 0); k++; end
    check(tag, {31'b0, rd_data[30]}, 32'h0);
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin step(0, 0); c += int'(pwm_out); end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    model_reset();
    wr_en = 0; wr_data = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset readback", rd_data, 32'h0);
    check("R9 reset output", {31'b0, pwm_out}, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    idle(3);
    check("R9 idle output after reset", {31'b0, pwm_out}, 32'h0);

    // R7: zero working step loads on the next enabled clock
    step(1, EN | REQ | 32'h0001_0040);
    check("R7 request visible", {31'b0, rd_data[30]}, 32'h1);
    step(0, 0);
    check("R7 loaded next clock", {31'b0, rd_data[30]}, 32'h0);

    // table walk: R2, R3, R8
    for (int v = 0; v < NVEC; v++) begin
      step(1, EN | REQ | {8'h0, VEC[v][39:24], VEC[v][23:16]});
      wait_loaded("R4 request cleared by boundary");
      idle(2);
      count_high(256, c);
      check($sformatf("R2 R3 R8 high count vec %0d", v), c, {16'h0, VEC[v][15:0]});
    end

    // R1: readback with unused bits written as ones
    step(1, 32'hBF12_3456);
    check("R1 readback masks gap", rd_data & 32'hBFFF_FFFF, 32'h8012_3456);
    wait_loaded("R5 request cleared");

    // R4: write without request leaves working settings
    step(1, EN | REQ | 32'h0001_0040);
    wait_loaded("R4 setup load");
    step(1, EN | 32'h0001_00FF);
    idle(2);
    count_high(256, c);
    check("R4 no-request write ignored", c, 64);

    // R5: request deferred until wrap; writing 0 to bit 30 keeps it
    step(1, EN | REQ | 32'h0001_00C0);
    check("R5 request set", {31'b0, rd_data[30]}, 32'h1);
    step(1, EN | 32'h0001_00C0);
    check("R5 zero write keeps request", {31'b0, rd_data[30]}, {31'b0, m_req});
    wait_loaded("R5 self clear");
    idle(2);
    count_high(256, c);
    check("R4 new duty after load", c, 192);

    // R6: disable parks low, re-enable restarts at phase zero
    step(1, 32'h0001_0040 | REQ);
    idle(4);
    check("R6 disabled low", {31'b0, pwm_out}, 32'h0);
    check("R10 request held while off", {31'b0, rd_data[30]}, 32'h1);
    step(1, EN | REQ | 32'h0001_0040);
    step(0, 0);
    check("R6 restart from phase zero", {31'b0, pwm_out}, 32'h1);
    wait_loaded("R10 loaded after enable");
    idle(2);
    count_high(256, c);
    check("R6 R10 duty after resume", c, 64);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule